// File: doc/BRIEF.md
# Supervisory Reset Generator

This block merges several reset causes into one processor reset and keeps that reset asserted for a fixed minimum time after the causes go away. Three causes are levels: a supply-low flag from an external voltage comparator, an active-low pushbutton input, and an active-low flag from a second comparator. The fourth cause is a one-cycle trip pulse from a watchdog counter. Reset stays asserted while any level cause is present, and for a stretch period after the last one clears. A watchdog trip gives a reset pulse of that same stretch length.

The three level inputs arrive asynchronously and pass through a synchronizer chain first. The pushbutton path then goes through a glitch filter. The filter changes its state only after the synchronized input has held the new value for a set number of consecutive cycles. Short spikes and contact bounce therefore never reach the reset. The reset is driven in both polarities, and a copy is provided as a status flag for neighbouring watchdog and chip-enable gating logic. All timings are parameters counted in clock cycles.

Top module: `sup_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, `man_rst_n_i` is 0 (after filtering) or `aux_rst_n_i` is 0, `rst_o` is 1.
- R2: After the last level cause clears, `rst_o` stays 1 for exactly `TRP_CYC` cycles beyond the last cycle in which the merged level hold was seen. For the supply and auxiliary inputs, a release applied just after clock edge k gives its last asserted sample just after edge k + `SYNC_STAGES` - 1 + `TRP_CYC`.
- R3: A `wdog_trip_i` pulse of one cycle, sampled 1 at edge k, asserts `rst_o` from edge k through edge k + `TRP_CYC` - 1, which is `TRP_CYC` cycles.
- R4: A low on `man_rst_n_i` that lasts fewer than `FILT_CYC` synchronized cycles has no effect on `rst_o`. A low of W >= `FILT_CYC` cycles gives W + `TRP_CYC` - 1 asserted cycles.
- R5: A bouncing pushbutton, meaning lows and highs each shorter than `FILT_CYC` around one long press, produces exactly one rising edge of `rst_o`.
- R6: `rst_n_o` is always the complement of `rst_o`, and `rst_active_o` always equals `rst_o`.
- R7: `rst_o` is 1 while `rst_n` is 0. After `rst_n` releases with all causes idle, it stays 1 for `TRP_CYC` + `SYNC_STAGES` - 1 cycles.
- R8: A level cause or watchdog trip that arrives during the stretch restarts the full `TRP_CYC` count from its own release, with no deassertion in between.
- R9: The supply and auxiliary inputs reach `rst_o` through `SYNC_STAGES` flops plus the stretch register: an assertion applied just after edge 0 first shows after edge `SYNC_STAGES` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Supply-below-threshold flag, asynchronous, active high |
| man_rst_n_i | input | 1 | Pushbutton reset, asynchronous, active low, may bounce |
| aux_rst_n_i | input | 1 | Auxiliary comparator reset flag, asynchronous, active low |
| wdog_trip_i | input | 1 | Watchdog timeout pulse, synchronous to clk, active high |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| rst_active_o | output | 1 | Reset-in-progress status for neighbouring blocks |

## Verification
The hardest situation to reach from the ports is the filter's acceptance boundary. It depends on how long the synchronized pushbutton level stays low, not on the pin, so the bench sweeps the pulse width across every value from one cycle to a few cycles past the filter length. For each width it checks the total asserted time, which is computed from the width, the filter length and the stretch length. A second hard case is restart inside the stretch. The bench injects an auxiliary low and a watchdog trip partway through a running stretch, then checks that the total asserted length has grown by the injection offset and that the reset never dropped.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  // Synchronized level inputs, one bit per asynchronous cause.
  typedef struct packed {
    logic supply_low;
    logic man_n;
    logic aux_n;
  } sup_in_t;

  // Value the synchronizer holds in reset: supply reported low, buttons idle.
  localparam sup_in_t SYNC_IDLE = '{supply_low: 1'b1, man_n: 1'b1, aux_n: 1'b1};

  // Bits needed to hold the values 0..n.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Merged level hold from the synchronized causes and the filtered button.
  function automatic logic hold_merge(input sup_in_t s, input logic man_pressed);
    return s.supply_low | man_pressed | ~s.aux_n;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOTAL = W * STAGES;

  logic [TOTAL-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[TOTAL-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[TOTAL-1 -: W];
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pressed_i,
  output logic pressed_o
);
  import sup_reset_pkg::*;

  localparam int FW = cnt_bits(FILT_CYC);

  logic state_q;

  generate
    if (FILT_CYC <= 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= pressed_i;
      end
    end else begin : g_filt
      logic [FW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state_q <= 1'b0;
          run_q   <= '0;
        end else if (pressed_i == state_q) begin
          run_q <= '0;
        end else if (run_q == FW'(FILT_CYC - 1)) begin
          state_q <= pressed_i;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  assign pressed_o = state_q;
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int TRP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic trip_i,
  output logic active_o
);
  import sup_reset_pkg::*;

  localparam int CW = cnt_bits(TRP_CYC);
  localparam logic [CW-1:0] LOAD = CW'(TRP_CYC);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= LOAD;
    else if (hold_i || trip_i) left_q <= LOAD;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int TRP_CYC     = 30_000_000,
  parameter int FILT_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic man_rst_n_i,
  input  logic aux_rst_n_i,
  input  logic wdog_trip_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic rst_active_o
);
  import sup_reset_pkg::*;

  localparam int IN_W = $bits(sup_in_t);

  sup_in_t sync_d;
  sup_in_t sync_q;
  logic    man_press_sync;
  logic    man_hold;
  logic    level_hold;
  logic    stretch_active;

  assign sync_d = '{supply_low: supply_low_i, man_n: man_rst_n_i, aux_n: aux_rst_n_i};

  sup_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign man_press_sync = ~sync_q.man_n;

  sup_glitch_filter #(
    .FILT_CYC (FILT_CYC)
  ) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pressed_i (man_press_sync),
    .pressed_o (man_hold)
  );

  assign level_hold = hold_merge(sync_q, man_hold);

  sup_stretch #(
    .TRP_CYC (TRP_CYC)
  ) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (level_hold),
    .trip_i   (wdog_trip_i),
    .active_o (stretch_active)
  );

  assign rst_o        = stretch_active;
  assign rst_n_o      = ~stretch_active;
  assign rst_active_o = stretch_active;
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic level_hold,
  input logic man_press_sync,
  input logic man_hold,
  input logic wdog_trip_i,
  input logic rst_o
);
  // R1
  hold_asserts_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_hold |=> rst_o);

  // R3
  trip_asserts_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_trip_i |=> rst_o);

  // R2
  release_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (!$past(level_hold) && !$past(wdog_trip_i)));

  // R1
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> ($past(level_hold) || $past(wdog_trip_i)));

  // R4
  filter_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (man_hold != $past(man_hold)) |-> ($past(man_press_sync) == man_hold));
endmodule

bind sup_reset_gen sup_reset_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .level_hold     (level_hold),
  .man_press_sync (man_press_sync),
  .man_hold       (man_hold),
  .wdog_trip_i    (wdog_trip_i),
  .rst_o          (rst_o)
);

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
  localparam int TRP  = 20;
  localparam int FILT = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_low_i = 1'b0;
  logic man_rst_n_i = 1'b1;
  logic aux_rst_n_i = 1'b1;
  logic wdog_trip_i = 1'b0;
  logic rst_n_o, rst_o, rst_active_o;

  int vectors = 0;
  int miscompares = 0;
  int pol_bad = 0;

  always #2.5 clk = ~clk;

  sup_reset_gen #(.TRP_CYC(TRP), .FILT_CYC(FILT), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low_i),
    .man_rst_n_i(man_rst_n_i), .aux_rst_n_i(aux_rst_n_i),
    .wdog_trip_i(wdog_trip_i), .rst_n_o(rst_n_o), .rst_o(rst_o),
    .rst_active_o(rst_active_o));

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One sample just after the falling edge; R6 polarity checked on every sample.
  task automatic sample(inout int hi, inout int rises, inout logic prev);
    @(negedge clk);
    if (rst_n_o !== ~rst_o || rst_active_o !== rst_o) pol_bad++;
    if (rst_o === 1'b1) hi++;
    if (rst_o === 1'b1 && prev !== 1'b1) rises++;
    prev = rst_o;
  endtask

  task automatic hold_supply(input int n);
    int hi = 0; int rs = 0; logic pv = rst_o;
    supply_low_i = 1'b1;
    for (int i = 1; i <= n; i++) sample(hi, rs, pv);
    // R1 / R9: first asserted sample after SYNC+1 edges
    check("R9", "supply assert samples", hi, n - SYNC);
  endtask

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 run watchdog: actual hung expected finished");
    summary_and_end();
  end

  initial begin
    int hi; int rs; logic pv;

    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7", "rst_o in reset", int'(rst_o), 1);
    check("R7", "rst_n_o in reset", int'(rst_n_o), 0);

    // R7: power-on stretch
    rst_n = 1'b1;
    hi = 0; rs = 0; pv = rst_o;
    for (int i = 1; i <= TRP + 10; i++) sample(hi, rs, pv);
    check("R7", "power-on asserted samples", hi, TRP + SYNC - 1);
    check("R7", "power-on final level", int'(rst_o), 0);

    // R4: pushbutton width sweep across the filter boundary
    for (int w = 1; w <= FILT + 3; w++) begin
      hi = 0; rs = 0; pv = rst_o;
      man_rst_n_i = 1'b0;
      for (int i = 1; i <= w + FILT + TRP + 6; i++) begin
        sample(hi, rs, pv);
        if (i == w) man_rst_n_i = 1'b1;
      end
      check("R4", $sformatf("width %0d asserted samples", w), hi,
            (w >= FILT) ? (w + TRP - 1) : 0);
      if (w >= FILT) check("R4", $sformatf("width %0d rises", w), rs, 1);
    end

    // R1 / R2: supply hold then release
    hold_supply(10);
    hi = 0; rs = 0; pv = rst_o;
    supply_low_i = 1'b0;
    for (int i = 1; i <= TRP + 10; i++) sample(hi, rs, pv);
    check("R2", "supply release stretch", hi, TRP + SYNC - 1);
    check("R2", "supply release no re-rise", rs, 0);

    // R1 / R2: auxiliary hold then release
    hi = 0; rs = 0; pv = rst_o;
    aux_rst_n_i = 1'b0;
    for (int i = 1; i <= 10; i++) sample(hi, rs, pv);
    check("R1", "aux assert samples", hi, 10 - SYNC);
    hi = 0; rs = 0; pv = rst_o;
    aux_rst_n_i = 1'b1;
    for (int i = 1; i <= TRP + 10; i++) sample(hi, rs, pv);
    check("R2", "aux release stretch", hi, TRP + SYNC - 1);

    // R3: watchdog trip from idle
    hi = 0; rs = 0; pv = rst_o;
    wdog_trip_i = 1'b1;
    for (int i = 1; i <= TRP + 10; i++) begin
      sample(hi, rs, pv);
      if (i == 1) wdog_trip_i = 1'b0;
    end
    check("R3", "watchdog pulse length", hi, TRP);
    check("R3", "watchdog pulse rises", rs, 1);

    // R8: auxiliary re-assertion inside the stretch
    hold_supply(10);
    hi = 0; rs = 0; pv = rst_o;
    supply_low_i = 1'b0;
    for (int i = 1; i <= TRP + 20; i++) begin
      sample(hi, rs, pv);
      if (i == 5) aux_rst_n_i = 1'b0;
      if (i == 8) aux_rst_n_i = 1'b1;
    end
    check("R8", "aux restart stretch", hi, 8 + SYNC - 1 + TRP);
    check("R8", "aux restart no gap", rs, 0);

    // R8: watchdog trip inside the stretch
    hold_supply(10);
    hi = 0; rs = 0; pv = rst_o;
    supply_low_i = 1'b0;
    for (int i = 1; i <= TRP + 20; i++) begin
      sample(hi, rs, pv);
      if (i == 5) wdog_trip_i = 1'b1;
      if (i == 6) wdog_trip_i = 1'b0;
    end
    check("R8", "watchdog restart stretch", hi, 5 + TRP);
    check("R8", "watchdog restart no gap", rs, 0);

    // R5: bouncing press and release give one reset event
    hi = 0; rs = 0; pv = rst_o;
    man_rst_n_i = 1'b0;
    for (int i = 1; i <= 46 + FILT + TRP + 10; i++) begin
      sample(hi, rs, pv);
      case (i)
        2, 5, 40, 43, 46: man_rst_n_i = 1'b1;
        3, 6, 42, 45:     man_rst_n_i = 1'b0;
        default: ;
      endcase
    end
    check("R5", "bounce rises", rs, 1);
    check("R5", "bounce asserted samples", hi, 46 - 6 + TRP - 1);

    // R6: polarity consistency over every sample taken
    check("R6", "polarity mismatches", pol_bad, 0);

    summary_and_end();
  end
endmodule